// File: doc/BRIEF.md
# Serial ADC Port Emulator

This block is the device side of a converter's three-wire serial port, written as synthesizable logic. A host drives chip select and a serial clock. The block supplies a parallel sample word from inside the chip. When chip select goes low, the block captures the sample, enters the hold state and turns its output driver on. It then shifts out a fixed 16-position frame, one bit per falling serial-clock edge. The frame starts with four zero bits, carries the sample most significant bit first, and is padded with zeros to the end.

Both host pins are brought into the system clock domain through synchronisers, and their edges are detected there. The output driver is controlled by a separate enable, so the pad can tri-state outside a frame. A hold output shows whether the modelled track-and-hold is holding or tracking. The sample width is chosen by a parameter and may be 8, 10 or 12 bits.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, `sdo_oe`, `sdo` and `hold` are all 0.
- R2: A falling edge on `csn_in` captures `sample_in` and sets `sdo_oe`=1, `hold`=1 and `sdo`=0, the first leading zero. Later changes to `sample_in` have no effect on the frame in progress.
- R3: After k falling `sclk_in` edges in a frame (k from 1 to 15), `sdo` carries frame position k. Positions 0 to 3 are zero. Positions 4 to 3+RES_BITS carry the sample MSB first. All later positions up to 15 are zero.
- R4: `hold` stays 1 up to and including the 13th falling `sclk_in` edge of a frame. It drops to 0 on the first rising `sclk_in` edge after the 13th falling edge.
- R5: The 16th falling `sclk_in` edge of a frame sets `sdo_oe` to 0.
- R6: A rising edge on `csn_in` before the frame is complete sets `sdo_oe`=0 and `hold`=0 and abandons the frame.
- R7: `sclk_in` edges have no effect while `csn_in` is high or after a frame has completed. Each falling edge of `csn_in` restarts the frame at position 0.
- R8: Whenever `sdo_oe` is 0, `sdo` is 0.
- R9: Outputs respond on the third rising `clk` edge after a pin change, and not before.
- R10: The frame layout of R3 holds for RES_BITS of 8, 10 and 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | Serial clock from the host, asynchronous |
| csn_in | input | 1 | Active-low chip select from the host, asynchronous |
| sample_in | input | RES_BITS | Parallel sample word to be sent |
| sdo | output | 1 | Serial data toward the host |
| sdo_oe | output | 1 | Output driver enable for the data pad |
| hold | output | 1 | 1 while holding, 0 while tracking |

## Verification
A bit counter that is off by one shows up at once as shifted data. The first affected bit appears three system clocks after the falling serial-clock edge that should have carried it. The same fault also moves the driver release by one serial-clock period and moves the hold release by one rising edge. A frame register that is not cleared on abort or completion shows as `sdo` high while the enable is low. The bench checks this after every such event. A counter that is not restarted on chip-select fall corrupts the leading zeros of the next frame. To catch that, the vector table runs an aborted frame right before a full one.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

  localparam int FRAME_LEN   = 16;
  localparam int LEAD_ZEROS  = 4;
  localparam int MAX_RES     = 12;
  localparam int TRACK_AFTER = 13;
  localparam int CNT_W       = $clog2(FRAME_LEN + 1);

  // Assemble the outgoing frame, position 0 in the MSB.
  function automatic logic [FRAME_LEN-1:0] build_frame(
    input logic [MAX_RES-1:0] smp,
    input int                 res
  );
    logic [FRAME_LEN-1:0] fr;
    fr = '0;
    for (int p = 0; p < FRAME_LEN; p++) begin
      if (p >= LEAD_ZEROS && p < LEAD_ZEROS + res) begin
        fr[FRAME_LEN-1-p] = smp[res-1-(p-LEAD_ZEROS)];
      end
    end
    return fr;
  endfunction

  // Track release condition: enough falling edges have been counted.
  function automatic logic release_due(input logic [CNT_W-1:0] falls);
    return int'(falls) >= TRACK_AFTER;
  endfunction

  // Frame completion: this falling edge is the last one.
  function automatic logic last_fall(input logic [CNT_W-1:0] falls);
    return int'(falls) == FRAME_LEN - 1;
  endfunction

endpackage

// File: rtl/adc_sp_sync.sv
module adc_sp_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] chain;
  logic              prev;
  logic              level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RESET_VAL}};
      prev  <= RESET_VAL;
    end else begin
      chain <= {chain[STAGES-2:0], pin};
      prev  <= level;
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;

  // R9: an edge pulse lasts a single cycle
  // R9
  one_cycle_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise || fall) |=> !(rise || fall));

endmodule

// File: rtl/adc_sp_seq.sv
module adc_sp_seq
  import adc_sp_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               abort,
  input  logic               shift,
  input  logic [MAX_RES-1:0] smp,
  output logic               sdo,
  output logic               oe,
  output logic               active,
  output logic [CNT_W-1:0]   falls
);

  logic [FRAME_LEN-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      falls  <= '0;
      oe     <= 1'b0;
      active <= 1'b0;
    end else if (start) begin
      shreg  <= build_frame(smp, RES_BITS);
      falls  <= '0;
      oe     <= 1'b1;
      active <= 1'b1;
    end else if (abort && active) begin
      shreg  <= '0;
      oe     <= 1'b0;
      active <= 1'b0;
    end else if (shift && active) begin
      falls <= falls + 1'b1;
      if (last_fall(falls)) begin
        shreg  <= '0;
        oe     <= 1'b0;
        active <= 1'b0;
      end else begin
        shreg <= {shreg[FRAME_LEN-2:0], 1'b0};
      end
    end
  end

  assign sdo = shreg[FRAME_LEN-1];

  // R5
  end_of_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && active && !start && !abort && last_fall(falls)) |=> !oe);

  // R7
  idle_shift_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !active && !start) |=> $stable(falls));

endmodule

// File: rtl/adc_sp_th.sv
module adc_sp_th
  import adc_sp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic             clk_rise,
  input  logic [CNT_W-1:0] falls,
  output logic             hold
);

  logic release_now;

  assign release_now = hold && clk_rise && release_due(falls);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= 1'b0;
    end else if (start) begin
      hold <= 1'b1;
    end else if (abort || release_now) begin
      hold <= 1'b0;
    end
  end

  // R4
  early_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !abort && !release_due(falls)) |=> hold);

  // R4
  release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> $past(clk_rise || abort));

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_sp_pkg::*;
#(
  parameter int RES_BITS    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk_in,
  input  logic                csn_in,
  input  logic [RES_BITS-1:0] sample_in,
  output logic                sdo,
  output logic                sdo_oe,
  output logic                hold
);

  generate
    if (!(RES_BITS == 8 || RES_BITS == 10 || RES_BITS == 12)) begin : g_bad_res
      $error("RES_BITS must be 8, 10 or 12");
    end
  endgenerate

  logic               cs_fall_ev;
  logic               cs_rise_ev;
  logic               sclk_fall_ev;
  logic               sclk_rise_ev;
  logic               frame_active;
  logic [CNT_W-1:0]   fall_count;
  logic [MAX_RES-1:0] smp_ext;

  assign smp_ext = MAX_RES'(sample_in);

  adc_sp_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_cs_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (csn_in),
    .rise (cs_rise_ev),
    .fall (cs_fall_ev)
  );

  adc_sp_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sclk_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (sclk_in),
    .rise (sclk_rise_ev),
    .fall (sclk_fall_ev)
  );

  adc_sp_seq #(.RES_BITS(RES_BITS)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (cs_fall_ev),
    .abort (cs_rise_ev),
    .shift (sclk_fall_ev),
    .smp   (smp_ext),
    .sdo   (sdo),
    .oe    (sdo_oe),
    .active(frame_active),
    .falls (fall_count)
  );

  adc_sp_th u_th (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (cs_fall_ev),
    .abort   (cs_rise_ev),
    .clk_rise(sclk_rise_ev),
    .falls   (fall_count),
    .hold    (hold)
  );

  // R2
  frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall_ev |=> (sdo_oe && hold && !sdo));

  // R6
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise_ev && !cs_fall_ev) |=> (!sdo_oe && !hold));

  // R8
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);

  // R7
  driver_only_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> frame_active);

endmodule

// File: tb/adc_serial_port_test.sv
`timescale 1ns/1ps
module adc_serial_port_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk_in = 1'b0;
  logic        csn_in = 1'b1;
  logic [11:0] sample_in = '0;
  logic        sdo, sdo_oe, hold;
  logic        sdo8, sdo_oe8, hold8;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  adc_serial_port #(.RES_BITS(12)) uut (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .csn_in(csn_in),
    .sample_in(sample_in), .sdo(sdo), .sdo_oe(sdo_oe), .hold(hold)
  );

  adc_serial_port #(.RES_BITS(8)) uut_r8 (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .csn_in(csn_in),
    .sample_in(sample_in[7:0]), .sdo(sdo8), .sdo_oe(sdo_oe8), .hold(hold8)
  );

  // {sample[11:0], falls before chip select rises (16 = full frame)}
  localparam logic [16:0] VEC [8] = '{
    {12'hA5C, 5'd16}, {12'hFFF, 5'd16}, {12'h000, 5'd16}, {12'h3C7, 5'd5},
    {12'h801, 5'd16}, {12'hFFF, 5'd13}, {12'h5A5, 5'd0},  {12'h6B9, 5'd16}
  };

  function automatic logic exp_bit(input logic [11:0] s, input int res, input int k);
    logic [15:0] f;
    f = 16'(s) << (12 - res);
    if (res == 8) f = 16'(s[7:0]) << 4;
    return f[15-k];
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    #2;
  endtask

  task automatic drive_cs(input logic v);
    @(negedge clk); csn_in = v; settle();
  endtask

  task automatic drive_sclk(input logic v);
    @(negedge clk); sclk_in = v; settle();
  endtask

  task automatic check_off(input string tag);
    chk({tag, " oe"},  16'(sdo_oe), 16'd0);
    chk({tag, " sdo"}, 16'(sdo),    16'd0);
    chk({tag, " r8 oe"}, 16'(sdo_oe8), 16'd0);
    chk({tag, " r8 sdo"}, 16'(sdo8), 16'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 during and after reset
    check_off("R1 in reset");
    chk("R1 hold", 16'(hold), 16'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk); #2;
    check_off("R1 after reset");
    chk("R1 hold after", 16'({hold, hold8}), 16'd0);

    // R9 latency: no response after two edges, response after the third
    @(negedge clk); sample_in = 12'h9E3; csn_in = 1'b0;
    repeat (2) @(posedge clk); #2;
    chk("R9 not yet", 16'(sdo_oe), 16'd0);
    @(posedge clk); #2;
    chk("R9 on third edge", 16'(sdo_oe), 16'd1);
    settle();
    drive_cs(1'b1);
    check_off("R6 idle abort");

    // R7 serial clock activity with chip select high
    for (int i = 0; i < 4; i++) begin
      drive_sclk(1'b1);
      drive_sclk(1'b0);
      check_off("R7 cs high");
      chk("R7 hold cs high", 16'({hold, hold8}), 16'd0);
    end

    // vector table
    for (int v = 0; v < 8; v++) begin
      logic [11:0] s;
      int          n;
      s = VEC[v][16:5];
      n = int'(VEC[v][4:0]);
      @(negedge clk); sample_in = s;
      drive_cs(1'b0);
      chk("R2 oe", 16'({sdo_oe, sdo_oe8}), 16'h3);
      chk("R2 hold", 16'({hold, hold8}), 16'h3);
      chk("R2 first zero", 16'({sdo, sdo8}), 16'h0);
      @(negedge clk); sample_in = ~s;  // R2: must not reach the frame
      for (int k = 1; k <= n; k++) begin
        drive_sclk(1'b1);
        if (k <= 13) chk("R4 still holding", 16'({hold, hold8}), 16'h3);
        else         chk("R4 tracking", 16'({hold, hold8}), 16'h0);
        drive_sclk(1'b0);
        if (k < 16) begin
          chk("R3 oe", 16'(sdo_oe), 16'd1);
          chk("R3 bit", {4'(k), 11'd0, sdo}, {4'(k), 11'd0, exp_bit(s, 12, k)});
          chk("R10 r8 bit", {4'(k), 11'd0, sdo8}, {4'(k), 11'd0, exp_bit(s, 8, k)});
        end else begin
          chk("R5 driver off", 16'({sdo_oe, sdo_oe8}), 16'h0);
          chk("R8 sdo low", 16'({sdo, sdo8}), 16'h0);
        end
      end
      if (n == 16) begin
        // R7 further clocks after the frame change nothing
        drive_sclk(1'b1);
        drive_sclk(1'b0);
        check_off("R7 after frame");
        drive_cs(1'b1);
      end else begin
        drive_cs(1'b1);
        check_off("R6 abort");
        chk("R6 hold", 16'({hold, hold8}), 16'h0);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule